// File: doc/BRIEF.md
# Pending Event Bit Vector Controller

The block keeps track of numbered asynchronous events aimed at a single receiving context. Every event type owns one pending flag and one flag that records whether a handler is installed. A send strobe carrying a type number raises that type's pending flag. Sending the same type again before it is delivered changes nothing, so repeats are not counted.

The delivery side always shows the pending type with the lowest number, together with the action the receiver must take for it. The action is to run the installed handler, to terminate, to terminate and dump, or to ignore the event. An acknowledge strobe retires the type that is being shown. Handlers are installed or removed through a registration strobe. One type, the kill type, always terminates, and any registration that names it is dropped.

Top module: `evt_pend_ctrl`

## Requirements
- R1: After reset (rst_ni low), pending_o is all zero, dlv_valid_o is 0, and no type has a handler installed.
- R2: A send (send_valid_i high) of type t sets pending_o[t] at the next clock edge. Bit t of pending_o belongs to type t.
- R3: Any number of sends of one type before its acknowledge leave a single pending bit, and one acknowledge clears it.
- R4: Type 9 is the kill type. Its action is always 2'b01 (terminate), and a registration that names type 9 has no effect.
- R5: dlv_valid_o is high exactly when some bit of pending_o is set. dlv_type_o is then the lowest-numbered pending type.
- R6: With ack_i high and dlv_valid_o high, the bit of the shown type clears at the next edge, and no other bit changes. ack_i with nothing pending has no effect.
- R7: If a send and an acknowledge hit the same type in the same cycle, that type's bit stays set.
- R8: The action encoding is 2'b00 handler, 2'b01 terminate, 2'b10 terminate-with-dump, 2'b11 ignore. With no handler installed, type 11 gives 2'b10, type 17 gives 2'b11, and every other type (including 2, 9 and 14) gives 2'b01.
- R9: A registration with reg_install_i=1 for a type other than 9 makes that type's action 2'b00 from the next cycle on. A registration with reg_install_i=0 restores the default action. Registrations never change pending_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| send_valid_i | input | 1 | Send strobe |
| send_type_i | input | 5 | Type number being sent |
| reg_valid_i | input | 1 | Handler registration strobe |
| reg_type_i | input | 5 | Type number being registered |
| reg_install_i | input | 1 | 1 installs a handler, 0 removes it |
| ack_i | input | 1 | Acknowledge of the shown type |
| dlv_valid_o | output | 1 | Some type is pending |
| dlv_type_o | output | 5 | Lowest pending type |
| dlv_action_o | output | 2 | Action for dlv_type_o |
| pending_o | output | 32 | Pending flag per type |

## Verification
A send and an acknowledge can land in the same cycle. They may name the same type or different types. The bench provokes the same-type case directly, by sending the type that is currently shown while acknowledging it, and then checks that its bit survives. The random phase sends low type numbers often enough that both the same-type and different-type cases recur. Every cycle, a bench model that applies the clear first and the set second predicts pending_o and the delivered type and action.

// File: rtl/evt_pkg.sv
package evt_pkg;
  typedef enum logic [1:0] {
    ACT_HANDLER = 2'b00,
    ACT_TERM    = 2'b01,
    ACT_DUMP    = 2'b10,
    ACT_IGNORE  = 2'b11
  } evt_act_e;
endpackage

// File: rtl/evt_pend_vec.sv
module evt_pend_vec #(
  parameter int NUM_TYPES = 32,
  localparam int TYPE_W = $clog2(NUM_TYPES)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 set_i,
  input  logic [TYPE_W-1:0]    set_type_i,
  input  logic                 clr_i,
  input  logic [TYPE_W-1:0]    clr_type_i,
  output logic [NUM_TYPES-1:0] pend_o
);
  for (genvar i = 0; i < NUM_TYPES; i++) begin : g_bit
    logic hit_set, hit_clr;
    assign hit_set = set_i && (set_type_i == TYPE_W'(i));
    assign hit_clr = clr_i && (clr_type_i == TYPE_W'(i));
    // set wins over clear so a fresh send is never lost
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      pend_o[i] <= 1'b0;
      else if (hit_set) pend_o[i] <= 1'b1;
      else if (hit_clr) pend_o[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/evt_hdl_tbl.sv
module evt_hdl_tbl #(
  parameter int NUM_TYPES = 32,
  parameter int KILL_TYPE = 9,
  localparam int TYPE_W = $clog2(NUM_TYPES)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 reg_valid_i,
  input  logic [TYPE_W-1:0]    reg_type_i,
  input  logic                 reg_install_i,
  output logic [NUM_TYPES-1:0] hdl_o
);
  for (genvar i = 0; i < NUM_TYPES; i++) begin : g_ent
    if (i == KILL_TYPE) begin : g_locked
      assign hdl_o[i] = 1'b0;
    end else begin : g_free
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) hdl_o[i] <= 1'b0;
        else if (reg_valid_i && reg_type_i == TYPE_W'(i)) hdl_o[i] <= reg_install_i;
      end
    end
  end
endmodule

// File: rtl/evt_prio_pick.sv
module evt_prio_pick #(
  parameter int NUM_TYPES = 32,
  localparam int TYPE_W = $clog2(NUM_TYPES)
) (
  input  logic [NUM_TYPES-1:0] req_i,
  output logic                 any_o,
  output logic [TYPE_W-1:0]    idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = NUM_TYPES - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = TYPE_W'(i);
    end
  end
  assign any_o = |req_i;
endmodule

// File: rtl/evt_act_map.sv
module evt_act_map
  import evt_pkg::*;
#(
  parameter int NUM_TYPES   = 32,
  parameter int KILL_TYPE   = 9,
  parameter int DUMP_TYPE   = 11,
  parameter int IGNORE_TYPE = 17,
  localparam int TYPE_W = $clog2(NUM_TYPES)
) (
  input  logic [TYPE_W-1:0]    type_i,
  input  logic [NUM_TYPES-1:0] hdl_i,
  output logic [1:0]           act_o
);
  evt_act_e dflt;
  always_comb begin
    if (type_i == TYPE_W'(DUMP_TYPE))        dflt = ACT_DUMP;
    else if (type_i == TYPE_W'(IGNORE_TYPE)) dflt = ACT_IGNORE;
    else                                     dflt = ACT_TERM;
    if (hdl_i[type_i] && type_i != TYPE_W'(KILL_TYPE)) act_o = ACT_HANDLER;
    else                                                act_o = dflt;
  end
endmodule

// File: rtl/evt_pend_ctrl.sv
module evt_pend_ctrl #(
  parameter int NUM_TYPES   = 32,
  parameter int KILL_TYPE   = 9,
  parameter int DUMP_TYPE   = 11,
  parameter int IGNORE_TYPE = 17,
  localparam int TYPE_W = $clog2(NUM_TYPES)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 send_valid_i,
  input  logic [TYPE_W-1:0]    send_type_i,
  input  logic                 reg_valid_i,
  input  logic [TYPE_W-1:0]    reg_type_i,
  input  logic                 reg_install_i,
  input  logic                 ack_i,
  output logic                 dlv_valid_o,
  output logic [TYPE_W-1:0]    dlv_type_o,
  output logic [1:0]           dlv_action_o,
  output logic [NUM_TYPES-1:0] pending_o
);
  logic [NUM_TYPES-1:0] hdl;
  logic                 ack_eff;

  assign ack_eff = ack_i && dlv_valid_o;

  evt_pend_vec #(.NUM_TYPES(NUM_TYPES)) u_pend (
    .clk_i, .rst_ni,
    .set_i(send_valid_i), .set_type_i(send_type_i),
    .clr_i(ack_eff),      .clr_type_i(dlv_type_o),
    .pend_o(pending_o)
  );

  evt_hdl_tbl #(.NUM_TYPES(NUM_TYPES), .KILL_TYPE(KILL_TYPE)) u_hdl (
    .clk_i, .rst_ni,
    .reg_valid_i, .reg_type_i, .reg_install_i,
    .hdl_o(hdl)
  );

  evt_prio_pick #(.NUM_TYPES(NUM_TYPES)) u_pick (
    .req_i(pending_o), .any_o(dlv_valid_o), .idx_o(dlv_type_o)
  );

  evt_act_map #(
    .NUM_TYPES(NUM_TYPES), .KILL_TYPE(KILL_TYPE),
    .DUMP_TYPE(DUMP_TYPE), .IGNORE_TYPE(IGNORE_TYPE)
  ) u_act (
    .type_i(dlv_type_o), .hdl_i(hdl), .act_o(dlv_action_o)
  );
endmodule

// File: rtl/evt_pend_ctrl_chk.sv
module evt_pend_ctrl_chk #(
  parameter int NUM_TYPES = 32,
  parameter int KILL_TYPE = 9,
  localparam int TYPE_W = $clog2(NUM_TYPES)
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 send_valid_i,
  input logic [TYPE_W-1:0]    send_type_i,
  input logic                 ack_i,
  input logic                 dlv_valid_o,
  input logic [TYPE_W-1:0]    dlv_type_o,
  input logic [1:0]           dlv_action_o,
  input logic [NUM_TYPES-1:0] pending_o
);
  logic [NUM_TYPES-1:0] below;
  assign below = (NUM_TYPES'(1) << dlv_type_o) - NUM_TYPES'(1);

  AST_SEND_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    send_valid_i |=> pending_o[$past(send_type_i)]); // R2
  AST_NO_PHANTOM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !send_valid_i |=> (pending_o & ~$past(pending_o)) == '0); // R3
  AST_KILL_TERM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dlv_valid_o && dlv_type_o == TYPE_W'(KILL_TYPE)) |-> dlv_action_o == 2'b01); // R4
  AST_LOWEST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dlv_valid_o |-> (pending_o[dlv_type_o] && (pending_o & below) == '0)); // R5
  AST_ACK_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && dlv_valid_o && !(send_valid_i && send_type_i == dlv_type_o))
      |=> !pending_o[$past(dlv_type_o)]); // R6
  AST_SEND_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && dlv_valid_o && send_valid_i && send_type_i == dlv_type_o)
      |=> pending_o[$past(dlv_type_o)]); // R7
endmodule

bind evt_pend_ctrl evt_pend_ctrl_chk #(.NUM_TYPES(NUM_TYPES), .KILL_TYPE(KILL_TYPE)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .send_valid_i(send_valid_i), .send_type_i(send_type_i),
  .ack_i(ack_i), .dlv_valid_o(dlv_valid_o), .dlv_type_o(dlv_type_o),
  .dlv_action_o(dlv_action_o), .pending_o(pending_o)
);

// File: tb/evt_pend_ctrl_bench.sv
module evt_pend_ctrl_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        send_valid_i = 1'b0;
  logic [4:0]  send_type_i = '0;
  logic        reg_valid_i = 1'b0;
  logic [4:0]  reg_type_i = '0;
  logic        reg_install_i = 1'b0;
  logic        ack_i = 1'b0;
  logic        dlv_valid_o;
  logic [4:0]  dlv_type_o;
  logic [1:0]  dlv_action_o;
  logic [31:0] pending_o;

  logic [31:0] m_pend, m_hdl;
  int n_chk = 0, n_fail = 0;

  always #5 clk_i = ~clk_i;

  evt_pend_ctrl u_evt_pend_ctrl (.*);

  function automatic int m_low(logic [31:0] v);
    for (int i = 31; i >= 0; i--) if (v[i]) m_low = i;
    if (v == 0) m_low = 0;
  endfunction

  function automatic logic [1:0] m_act(int t, logic [31:0] h);
    if (t != 9 && h[t]) return 2'b00;
    if (t == 11) return 2'b10;
    if (t == 17) return 2'b11;
    return 2'b01;
  endfunction

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic cmp_all(string req);
    chk({req, " pending"}, pending_o, m_pend);
    chk({req, " valid"}, 32'(dlv_valid_o), 32'(m_pend != 0));
    if (m_pend != 0) begin
      chk({req, " type"}, 32'(dlv_type_o), 32'(m_low(m_pend)));
      chk({req, " action"}, 32'(dlv_action_o), 32'(m_act(m_low(m_pend), m_hdl)));
    end
  endtask

  // inputs set at negedge, model updated at posedge, outputs compared at next negedge
  task automatic cyc(bit s, int st, bit a, bit r, int rt, bit ri, string req);
    send_valid_i = s; send_type_i = 5'(st); ack_i = a;
    reg_valid_i = r; reg_type_i = 5'(rt); reg_install_i = ri;
    @(posedge clk_i);
    if (a && m_pend != 0) m_pend[m_low(m_pend)] = 1'b0;
    if (s) m_pend[st] = 1'b1;
    if (r && rt != 9) m_hdl[rt] = ri;
    @(negedge clk_i);
    send_valid_i = 0; ack_i = 0; reg_valid_i = 0;
    cmp_all(req);
  endtask

  task automatic drain();
    while (m_pend != 0) cyc(0, 0, 1, 0, 0, 0, "R6_drain");
  endtask

  initial begin
    #(10 * 150000);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int seed;
    m_pend = '0; m_hdl = '0;
    seed = $urandom(32'd4242);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    cmp_all("R1_reset");
    chk("R1 dlv_valid", 32'(dlv_valid_o), 0);

    cyc(1, 5, 0, 0, 0, 0, "R2_send5");
    chk("R2 bit5", 32'(pending_o[5]), 1);
    cyc(1, 5, 0, 0, 0, 0, "R3_repeat");
    cyc(1, 5, 0, 0, 0, 0, "R3_repeat");
    cyc(0, 0, 1, 0, 0, 0, "R3_single_ack");
    chk("R3 cleared", pending_o, 0);

    cyc(0, 0, 0, 1, 9, 1, "R4_reg_kill");
    cyc(1, 9, 0, 0, 0, 0, "R4_send_kill");
    chk("R4 action", 32'(dlv_action_o), 32'h1);
    chk("R9 reg no pend effect", pending_o, 32'h200);
    drain();

    cyc(1, 20, 0, 0, 0, 0, "R5_send20");
    cyc(1, 3, 0, 0, 0, 0, "R5_send3");
    chk("R5 lowest", 32'(dlv_type_o), 3);
    cyc(0, 0, 1, 0, 0, 0, "R6_ack3");
    chk("R6 only3 cleared", pending_o, 32'h0010_0000);
    drain();
    cyc(0, 0, 1, 0, 0, 0, "R6_ack_empty");
    chk("R6 empty ack", pending_o, 0);

    cyc(1, 7, 0, 0, 0, 0, "R7_prep");
    cyc(1, 7, 1, 0, 0, 0, "R7_same_cycle");
    chk("R7 kept", 32'(pending_o[7]), 1);
    cyc(1, 2, 1, 0, 0, 0, "R7_diff_type");
    chk("R7 diff", pending_o, 32'h4);
    drain();

    foreach (m_pend[i]) if (i == 2 || i == 11 || i == 14 || i == 17) m_pend[i] = m_pend[i];
    cyc(1, 17, 0, 0, 0, 0, "R8_s17");
    chk("R8 ignore", 32'(dlv_action_o), 32'h3);
    cyc(1, 14, 0, 0, 0, 0, "R8_s14");
    chk("R8 term14", 32'(dlv_action_o), 32'h1);
    cyc(1, 11, 0, 0, 0, 0, "R8_s11");
    chk("R8 dump", 32'(dlv_action_o), 32'h2);
    cyc(1, 2, 0, 0, 0, 0, "R8_s2");
    chk("R8 term2", 32'(dlv_action_o), 32'h1);
    drain();

    cyc(1, 17, 0, 1, 17, 1, "R9_install");
    chk("R9 handler", 32'(dlv_action_o), 32'h0);
    cyc(0, 0, 0, 1, 17, 0, "R9_remove");
    chk("R9 restored", 32'(dlv_action_o), 32'h3);
    drain();

    for (int k = 0; k < 3000; k++) begin
      bit s, a, r, ri;
      int st, rt;
      s  = ($urandom % 2) == 0;
      st = ($urandom % 3 == 0) ? int'($urandom % 32) : int'($urandom % 12);
      a  = ($urandom % 3) == 0;
      if (a && m_pend != 0 && ($urandom % 4) == 0) begin s = 1; st = m_low(m_pend); end
      r  = ($urandom % 8) == 0;
      rt = int'($urandom % 32);
      ri = ($urandom % 2) == 0;
      cyc(s, st, a, r, rt, ri, "R5_R8_random");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule